// File: doc/BRIEF.md
# Parallel Row-Access Discharge Timer Scanner

This block reads out a resistive sensor array of ROWS sensor rows and COLS columns that is wired straight to device pins. Every column has one capacitor on a shared node pin, and every sensor has its own resistor pin. For each row, the block first charges all column capacitors by driving the node pins high while every resistor pin floats. It then pulls the selected row's resistor pins low and releases the node pins so that they can be sensed. COLS timers start together, and each timer stops on its own when its column node is first read as logic 0.

The scan runs through the sensor rows in order and then through one extra calibration row. Each calibration resistor sits on its own group of pins. After each row, the block emits a vector of COLS discharge counts and COLS overflow flags with a one-cycle valid strobe and the row index. A host later divides the sensor counts by the calibration counts to obtain resistance. Pin enables are given as plain vectors, and the pads themselves sit outside the block.

Top module: `rdt_scanner`

## Requirements
- R1: In the charge phase every bit of `node_oe` is 1 and every bit of `rpin_oe` is 0. The phase lasts max(`charge_len`,2) clock cycles.
- R2: In the discharge phase of row r, bits r*COLS to r*COLS+COLS-1 of `rpin_oe` are 1 (pin driven low), all other bits are 0, and `node_oe` is 0.
- R3: At most one row group of `rpin_oe` is enabled in any cycle, and `node_oe` and `rpin_oe` are never both nonzero.
- R4: The discharge cycles of a row are numbered from 0, where cycle 0 is the first cycle in which the row is driven. The count for a column is the number of the cycle at whose closing clock edge `node_in` for that column is first sampled as 0. This numbering removes the two-flop synchronizer delay, and every column is timed on its own.
- R5: One scan visits rows 0 to ROWS-1 and then the calibration row, whose index is ROWS and whose pins are the top COLS bits of `rpin_oe`. `res_row` reports the row index.
- R6: If a column is not sampled low by the end of cycle `tmo_lim`, its overflow flag is 1 and its count is `tmo_lim`. A first low sample at cycle `tmo_lim` exactly is reported as a normal count with the flag at 0.
- R7: `res_valid` is a one-cycle pulse for each row. `res_cnt` (column c in bits c*CNT_W and up) and `res_ovf` hold their values until the next pulse.
- R8: After each discharge phase there is at least one cycle with all of `rpin_oe` and `node_oe` at 0 before the next charge phase starts.
- R9: `scan_go` starts a scan only while `busy` is 0. A pulse while `busy` is 1 has no effect.
- R10: After reset, `rpin_oe`, `node_oe`, `res_valid` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_go | input | 1 | Start one full scan |
| charge_len | input | CHG_W | Charge phase length in cycles (minimum 2 applied) |
| tmo_lim | input | CNT_W | Discharge count limit |
| node_in | input | COLS | Asynchronous column node levels |
| node_oe | output | COLS | Drive column nodes high when 1 |
| rpin_oe | output | (ROWS+1)*COLS | Drive resistor pin low when 1, float when 0 |
| busy | output | 1 | Scan in progress |
| res_valid | output | 1 | Row result strobe |
| res_row | output | RW | Row index of the result, ROWS for calibration |
| res_cnt | output | COLS*CNT_W | Per-column discharge counts |
| res_ovf | output | COLS | Per-column overflow flags |

## Verification
A column's stop and the timeout of that column can happen at the same clock edge. This happens when the first low sample falls exactly at cycle `tmo_lim`. The bench makes this happen by placing one column's modelled discharge at the limit and a second column's discharge one cycle beyond it. The stop must win and give a plain count of `tmo_lim` with no flag, while the later column gets the flag and the same count. Stops on several columns in one cycle are covered by giving equal delays within a row.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_CHARGE = 2'd1,
    PH_DISCH  = 2'd2,
    PH_GAP    = 2'd3
  } rdt_phase_e;
endpackage

// File: rtl/rdt_sync.sv
module rdt_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
      end else begin
        s1 <= d_async[i];
        s2 <= s1;
      end
    end
    assign q_sync[i] = s2;
  end
endmodule

// File: rtl/rdt_col_timer.sv
module rdt_col_timer #(
  parameter int CNT_W = 12,
  localparam int TW = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic             node_sync,
  input  logic [TW-1:0]    tick,
  input  logic [CNT_W-1:0] lim,
  output logic             done,
  output logic             ovf,
  output logic [CNT_W-1:0] cnt
);
  logic [TW-1:0] lim_end;
  assign lim_end = TW'(lim) + TW'(2);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      done <= 1'b0;
      ovf  <= 1'b0;
      cnt  <= '0;
    end else if (run && !done) begin
      if (!node_sync) begin
        done <= 1'b1;
        cnt  <= CNT_W'(tick - TW'(2));
      end else if (tick == lim_end) begin
        done <= 1'b1;
        ovf  <= 1'b1;
        cnt  <= lim;
      end
    end
  end

  AST_HOLD_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    (done && !clear) |=> $stable(cnt)) else $error("count moved after stop"); // R4
  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (rst)
    (run && !done) |-> (tick <= lim_end)) else $error("timer ran past limit"); // R6
  AST_OVF_IMPLIES_DONE: assert property (@(posedge clk) disable iff (rst)
    ovf |-> done) else $error("overflow without stop"); // R6
endmodule

// File: rtl/rdt_seq.sv
module rdt_seq
  import rdt_pkg::*;
#(
  parameter int ROWS  = 3,
  parameter int CHG_W = 8,
  parameter int CNT_W = 12,
  localparam int RW = $clog2(ROWS + 1),
  localparam int TW = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_go,
  input  logic [CHG_W-1:0] charge_len,
  input  logic             all_done,
  output rdt_phase_e       phase,
  output logic [RW-1:0]    row_idx,
  output logic [TW-1:0]    tick
);
  logic [CHG_W-1:0] ccnt;
  logic [CHG_W-1:0] chg_eff;

  assign chg_eff = (charge_len < CHG_W'(2)) ? CHG_W'(2) : charge_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      row_idx <= '0;
      ccnt    <= '0;
      tick    <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (scan_go) begin
            phase   <= PH_CHARGE;
            row_idx <= '0;
            ccnt    <= '0;
          end
        end
        PH_CHARGE: begin
          ccnt <= ccnt + CHG_W'(1);
          tick <= '0;
          if (ccnt + CHG_W'(1) >= chg_eff) phase <= PH_DISCH;
        end
        PH_DISCH: begin
          tick <= tick + TW'(1);
          if (all_done) phase <= PH_GAP;
        end
        default: begin
          ccnt <= '0;
          if (row_idx == RW'(ROWS)) begin
            phase <= PH_IDLE;
          end else begin
            row_idx <= row_idx + RW'(1);
            phase   <= PH_CHARGE;
          end
        end
      endcase
    end
  end

  AST_GAP_FOLLOWS_DISCH: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DISCH) |=> (phase == PH_DISCH || phase == PH_GAP)) else $error("discharge left without gap"); // R8
  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    row_idx <= RW'(ROWS)) else $error("row index out of range"); // R5
endmodule

// File: rtl/rdt_scanner.sv
module rdt_scanner
  import rdt_pkg::*;
#(
  parameter int ROWS  = 3,
  parameter int COLS  = 4,
  parameter int CNT_W = 12,
  parameter int CHG_W = 8,
  localparam int RW = $clog2(ROWS + 1),
  localparam int NPIN = (ROWS + 1) * COLS,
  localparam int TW = CNT_W + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scan_go,
  input  logic [CHG_W-1:0]      charge_len,
  input  logic [CNT_W-1:0]      tmo_lim,
  input  logic [COLS-1:0]       node_in,
  output logic [COLS-1:0]       node_oe,
  output logic [NPIN-1:0]       rpin_oe,
  output logic                  busy,
  output logic                  res_valid,
  output logic [RW-1:0]         res_row,
  output logic [COLS*CNT_W-1:0] res_cnt,
  output logic [COLS-1:0]       res_ovf
);
  rdt_phase_e       phase;
  logic [RW-1:0]    row_idx;
  logic [TW-1:0]    tick;
  logic [COLS-1:0]  node_sync;
  logic [COLS-1:0]  col_done;
  logic [COLS-1:0]  col_ovf;
  logic [COLS*CNT_W-1:0] col_cnt;
  logic [ROWS:0]    grp_act;
  logic             all_done;

  assign all_done = &col_done;

  rdt_seq #(.ROWS(ROWS), .CHG_W(CHG_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .scan_go(scan_go), .charge_len(charge_len),
    .all_done(all_done), .phase(phase), .row_idx(row_idx), .tick(tick)
  );

  rdt_sync #(.WIDTH(COLS)) u_sync (
    .clk(clk), .rst(rst), .d_async(node_in), .q_sync(node_sync)
  );

  for (genvar c = 0; c < COLS; c++) begin : g_col
    rdt_col_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst(rst),
      .clear(phase == PH_CHARGE),
      .run(phase == PH_DISCH),
      .node_sync(node_sync[c]),
      .tick(tick), .lim(tmo_lim),
      .done(col_done[c]), .ovf(col_ovf[c]),
      .cnt(col_cnt[c*CNT_W +: CNT_W])
    );
  end

  for (genvar g = 0; g <= ROWS; g++) begin : g_grp
    assign grp_act[g] = (phase == PH_DISCH) && (row_idx == RW'(g));
    assign rpin_oe[g*COLS +: COLS] = {COLS{grp_act[g]}};
  end

  assign node_oe = {COLS{phase == PH_CHARGE}};
  assign busy    = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_row   <= '0;
      res_cnt   <= '0;
      res_ovf   <= '0;
    end else begin
      res_valid <= 1'b0;
      if (phase == PH_DISCH && all_done) begin
        res_valid <= 1'b1;
        res_row   <= row_idx;
        res_cnt   <= col_cnt;
        res_ovf   <= col_ovf;
      end
    end
  end

  AST_ONE_ROW_GROUP: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grp_act)) else $error("two row groups driven"); // R3
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    !((|node_oe) && (|rpin_oe))) else $error("node and row driven together"); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid) else $error("valid longer than one cycle"); // R7
  AST_IDLE_BEFORE_CHARGE: assert property (@(posedge clk) disable iff (rst)
    $rose(node_oe[0]) |-> ($past(rpin_oe) == '0)) else $error("charge right after discharge"); // R8
endmodule

// File: tb/sim_rdt_scanner.sv
module sim_rdt_scanner;
  localparam int ROWS = 3, COLS = 4, CNT_W = 12, CHG_W = 8;
  localparam int RW = $clog2(ROWS + 1), NPIN = (ROWS + 1) * COLS;
  localparam int NEVER = 1000000;

  logic clk = 1'b0, rst = 1'b1, scan_go = 1'b0;
  logic [CHG_W-1:0] charge_len = 8'd5;
  logic [CNT_W-1:0] tmo_lim = 12'd300;
  logic [COLS-1:0] node_in = '1;
  logic [COLS-1:0] node_oe;
  logic [NPIN-1:0] rpin_oe;
  logic busy, res_valid;
  logic [RW-1:0] res_row;
  logic [COLS*CNT_W-1:0] res_cnt;
  logic [COLS-1:0] res_ovf;

  always #4 clk = ~clk;

  rdt_scanner #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W), .CHG_W(CHG_W)) u0 (
    .clk(clk), .rst(rst), .scan_go(scan_go), .charge_len(charge_len),
    .tmo_lim(tmo_lim), .node_in(node_in), .node_oe(node_oe), .rpin_oe(rpin_oe),
    .busy(busy), .res_valid(res_valid), .res_row(res_row), .res_cnt(res_cnt),
    .res_ovf(res_ovf)
  );

  int total = 0, bad = 0, cyc = 0;
  int dly [ROWS+1][COLS];
  int ncnt [COLS];
  int got_cnt [ROWS+1][COLS];
  int got_ovf [ROWS+1][COLS];
  int vcount = 0, order_err = 0, clen = 0, last_clen = 0;
  int v_contend = 0, v_multi = 0, v_part = 0, v_gap = 0, v_pulse = 0;
  logic [COLS-1:0] prev_noe = '0;
  logic [NPIN-1:0] prev_roe = '0;
  logic prev_valid = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // capacitor model and monitors, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    for (int c = 0; c < COLS; c++) begin
      if (node_oe[c]) begin
        node_in[c] = 1'b1;
        ncnt[c] = 0;
      end else begin
        for (int r = 0; r <= ROWS; r++) begin
          if (rpin_oe[r*COLS+c]) begin
            if (ncnt[c] == dly[r][c]) node_in[c] = 1'b0;
            ncnt[c]++;
          end
        end
      end
    end
    if (!rst) begin
      int groups;
      groups = 0;
      for (int r = 0; r <= ROWS; r++) begin
        if (|rpin_oe[r*COLS +: COLS]) begin
          groups++;
          if (rpin_oe[r*COLS +: COLS] != '1) v_part++;
        end
      end
      if (groups > 1) v_multi++;
      if ((|node_oe) && (|rpin_oe)) v_contend++;
      if ((node_oe != '0) && (node_oe != '1)) v_part++;
      if ((prev_noe == '0) && (node_oe == '1) && (prev_roe != '0)) v_gap++;
      if (res_valid && prev_valid) v_pulse++;
      if (&node_oe) clen++;
      else if (clen != 0) begin
        last_clen = clen;
        clen = 0;
      end
      if (res_valid) begin
        if (int'(res_row) != vcount) order_err++;
        if (int'(res_row) <= ROWS)
          for (int c = 0; c < COLS; c++) begin
            got_cnt[res_row][c] = int'(res_cnt[c*CNT_W +: CNT_W]);
            got_ovf[res_row][c] = int'(res_ovf[c]);
          end
        vcount++;
      end
      prev_noe = node_oe;
      prev_roe = rpin_oe;
      prev_valid = res_valid;
    end
  end

  task automatic run_scan();
    vcount = 0;
    order_err = 0;
    @(negedge clk) scan_go = 1'b1;
    @(negedge clk) scan_go = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pin_checks(input string tag);
    chk(v_contend == 0, {tag, " R3 contention"}, v_contend, 0);
    chk(v_multi == 0, {tag, " R3 multi-row"}, v_multi, 0);
    chk(v_part == 0, {tag, " R2 partial group"}, v_part, 0);
    chk(v_gap == 0, {tag, " R8 gap"}, v_gap, 0);
    chk(v_pulse == 0, {tag, " R7 pulse width"}, v_pulse, 0);
  endtask

  task automatic t_reset();
    chk(rpin_oe == '0, "R10 rpin_oe", int'(rpin_oe), 0);
    chk(node_oe == '0, "R10 node_oe", int'(node_oe), 0);
    chk(res_valid == 1'b0, "R10 res_valid", int'(res_valid), 0);
    chk(busy == 1'b0, "R10 busy", int'(busy), 0);
  endtask

  task automatic t_basic();
    charge_len = 8'd5;
    tmo_lim = 12'd300;
    for (int r = 0; r <= ROWS; r++)
      for (int c = 0; c < COLS; c++) dly[r][c] = 10 + 7*r + 3*c;
    dly[1][0] = 0;
    dly[1][1] = 0;
    run_scan();
    chk(vcount == ROWS + 1, "R5 R7 row count", vcount, ROWS + 1);
    chk(order_err == 0, "R5 row order", order_err, 0);
    chk(last_clen == 5, "R1 charge length", last_clen, 5);
    for (int r = 0; r <= ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        chk(got_cnt[r][c] == dly[r][c], $sformatf("R4 count r%0d c%0d", r, c),
            got_cnt[r][c], dly[r][c]);
        chk(got_ovf[r][c] == 0, "R6 no overflow", got_ovf[r][c], 0);
      end
    pin_checks("basic");
  endtask

  task automatic t_timeout();
    charge_len = 8'd3;
    tmo_lim = 12'd20;
    for (int r = 0; r <= ROWS; r++)
      for (int c = 0; c < COLS; c++) dly[r][c] = 5;
    dly[0][0] = 20;
    dly[0][1] = 21;
    dly[0][2] = NEVER;
    dly[0][3] = 0;
    dly[ROWS][1] = NEVER;
    run_scan();
    chk(got_cnt[0][0] == 20 && got_ovf[0][0] == 0, "R6 stop at limit", got_cnt[0][0], 20);
    chk(got_ovf[0][0] == 0, "R6 stop-at-limit flag", got_ovf[0][0], 0);
    chk(got_cnt[0][1] == 20 && got_ovf[0][1] == 1, "R6 one past limit", got_ovf[0][1], 1);
    chk(got_cnt[0][2] == 20 && got_ovf[0][2] == 1, "R6 never low", got_cnt[0][2], 20);
    chk(got_cnt[0][3] == 0 && got_ovf[0][3] == 0, "R4 immediate low", got_cnt[0][3], 0);
    chk(got_ovf[ROWS][1] == 1, "R5 R6 calibration overflow", got_ovf[ROWS][1], 1);
    chk(got_cnt[ROWS][0] == 5, "R5 calibration count", got_cnt[ROWS][0], 5);
    chk(got_cnt[2][3] == 5, "R4 equal stops", got_cnt[2][3], 5);
    pin_checks("timeout");
  endtask

  task automatic t_min_charge();
    tmo_lim = 12'd100;
    for (int r = 0; r <= ROWS; r++)
      for (int c = 0; c < COLS; c++) dly[r][c] = 4 + c;
    charge_len = 8'd0;
    run_scan();
    chk(last_clen == 2, "R1 charge floor from 0", last_clen, 2);
    chk(got_cnt[2][1] == 5, "R4 count after short charge", got_cnt[2][1], 5);
    charge_len = 8'd1;
    run_scan();
    chk(last_clen == 2, "R1 charge floor from 1", last_clen, 2);
    chk(got_cnt[0][0] == 4 && got_ovf[0][0] == 0, "R4 no false stop", got_cnt[0][0], 4);
    pin_checks("mincharge");
  endtask

  task automatic t_busy_ignore();
    charge_len = 8'd4;
    tmo_lim = 12'd60;
    for (int r = 0; r <= ROWS; r++)
      for (int c = 0; c < COLS; c++) dly[r][c] = 30;
    vcount = 0;
    @(negedge clk) scan_go = 1'b1;
    @(negedge clk) scan_go = 1'b0;
    repeat (60) @(negedge clk);
    chk(busy == 1'b1, "R9 busy mid-scan", int'(busy), 1);
    scan_go = 1'b1;
    @(negedge clk) scan_go = 1'b0;
    while (busy) @(negedge clk);
    repeat (150) @(negedge clk);
    chk(vcount == ROWS + 1, "R9 second go ignored", vcount, ROWS + 1);
    chk(busy == 1'b0, "R9 idle after scan", int'(busy), 0);
    pin_checks("busy");
  endtask

  initial begin
    for (int r = 0; r <= ROWS; r++)
      for (int c = 0; c < COLS; c++) dly[r][c] = NEVER;
    for (int c = 0; c < COLS; c++) ncnt[c] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_timeout();
    t_min_charge();
    t_busy_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule